// File: doc/BRIEF.md
# I2C Target Receive Engine with 7/10-bit Addressing

This block is the receive side of an I2C target. It watches the clock and data lines through a glitch filter and detects START and STOP conditions. It shifts bits on each rising clock edge. It compares the first byte after a START against a host-loaded address register, and it pulls the data line low during the ninth clock pulse when a byte is accepted. Each accepted byte moves from the hidden shift register into a host-readable buffer. Because of this split, the next byte can arrive while the host has not yet read the previous one.

A single interrupt flag marks every accepted byte and every bus event. Status outputs report the last bus condition, whether the buffer holds an address or data, and the direction of the transfer. An overflow bit sets when a byte finishes while the buffer is still unread. In 10-bit mode the host first loads the high-byte pattern. When that pattern matches, the block raises a reload request. The host then writes the low address byte, which the block compares against the next received byte.

Top module: `i2c_rx_target`

## Requirements
- R1: After reset, irq_o, ovf_o, full_o, start_o, stop_o, is_data_o, is_read_o, upd_addr_o and sda_pull_o are all 0.
- R2: While en_i is 0, bus activity is ignored: no START/STOP status, no interrupt, no buffer load, and sda_pull_o stays 0.
- R3: A START (filtered SDA falls while filtered SCL is high) sets start_o, clears stop_o and sets irq_o. A STOP (SDA rises while SCL is high) sets stop_o, clears start_o and sets irq_o.
- R4: In 7-bit mode (ten_bit_i=0), a first byte whose bits [7:1] equal address register bits [7:1] is acknowledged. The whole byte is loaded into buf_o, full_o and irq_o set, is_data_o becomes 0, and is_read_o takes byte bit 0 (1 = read).
- R5: A first byte that does not match is not acknowledged. The rest of the transfer up to the next START or STOP is ignored, and full_o stays 0.
- R6: After a matched write address, each data byte is acknowledged and loaded into buf_o with is_data_o=1.
- R7: A one-cycle pulse of buf_rd_i clears full_o. irq_o clears only on irq_clr_i, and ovf_o clears only on ovf_clr_i.
- R8: If a byte completes while full_o is 1, ovf_o and irq_o are set, the byte is not acknowledged, and buf_o keeps its old value.
- R9: In 10-bit mode, a first byte with bits [7:3]=11110 and bits [7:1] equal to the address register bits [7:1] is acknowledged. If its bit 0 is 0, upd_addr_o is set.
- R10: A write to the address register (addr_wr_i) clears upd_addr_o. In 10-bit mode, the byte after the high byte is acknowledged only if all 8 bits equal the address register. The transfer then continues as data (R6).
- R11: A 10-bit low byte that differs from the address register is not acknowledged and is not loaded.
- R12: A line pulse shorter than FILT_LEN system clocks (default 3) is removed: a 2-clock low pulse on SDA while SCL is high creates no START.
- R13: sda_pull_o rises only while the filtered SCL is low. It is released on the SCL falling edge that ends the ninth pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable |
| ten_bit_i | input | 1 | 1 = 10-bit address mode, 0 = 7-bit |
| scl_i | input | 1 | Raw I2C clock line level |
| sda_i | input | 1 | Raw I2C data line level |
| sda_pull_o | output | 1 | 1 = pull SDA low (acknowledge) |
| addr_wr_i | input | 1 | Host write strobe for the address register |
| addr_wdata_i | input | 8 | Address register write data |
| buf_rd_i | input | 1 | Host read strobe for the receive buffer |
| buf_o | output | 8 | Receive buffer |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| ovf_clr_i | input | 1 | Clears the overflow bit |
| irq_o | output | 1 | Interrupt flag |
| ovf_o | output | 1 | Receive overflow |
| full_o | output | 1 | Buffer holds an unread byte |
| start_o | output | 1 | Last bus event was START |
| stop_o | output | 1 | Last bus event was STOP |
| is_data_o | output | 1 | Buffer byte is data (1) or address (0) |
| is_read_o | output | 1 | Transfer direction is read |
| upd_addr_o | output | 1 | Host must load the 10-bit low address byte |

## Verification
Address bytes are tried as 7-bit matches, 7-bit mismatches, read-direction matches, 10-bit high bytes followed by matching and mismatching low bytes, and data bytes. These cases separate the compare width and the reload request from the acknowledge decision. A second byte sent before the host reads shows that an overflow keeps the old buffer value and withholds the acknowledge. A sub-filter pulse on SDA and traffic while disabled show that the filter and the enable each block START detection.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
    localparam int BYTE_W = 8;
    localparam int BITC_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR1,
        ST_ADDR2,
        ST_DATA,
        ST_SKIP
    } rx_state_e;

    typedef struct packed {
        rx_state_e         st;
        logic [BYTE_W-1:0] sr;
        logic [BITC_W-1:0] cnt;
        logic              ack;
        logic              pull;
        logic [BYTE_W-1:0] buf_b;
        logic              full;
        logic              ovf;
        logic              irq;
        logic              start;
        logic              stop;
        logic              is_data;
        logic              is_read;
        logic              upd;
        logic [BYTE_W-1:0] addr;
    } rx_regs_t;
endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_i,
    output logic out_o
);
    localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          lvl;
    } filt_t;

    filt_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (in_i == f_q.lvl) begin
            f_d.cnt = '0;
        end else if (f_q.cnt == CW'(FILT_LEN - 1)) begin
            f_d.lvl = in_i;
            f_d.cnt = '0;
        end else begin
            f_d.cnt = f_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '{cnt: '0, lvl: 1'b1};
        end else begin
            f_q <= f_d;
        end
    end

    assign out_o = f_q.lvl;

    // R12: the accepted level only changes to a value the input already had
    a_r12_filter_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(f_q.lvl) |-> (f_q.lvl == $past(in_i)));
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f_i,
    input  logic sda_f_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_ev_o,
    output logic stop_ev_o
);
    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t p_d, p_q;

    always_comb begin
        p_d.scl = scl_f_i;
        p_d.sda = sda_f_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            p_q <= p_d;
        end
    end

    assign scl_rise_o = scl_f_i & ~p_q.scl;
    assign scl_fall_o = ~scl_f_i & p_q.scl;
    assign start_ev_o = scl_f_i & p_q.scl & p_q.sda & ~sda_f_i;
    assign stop_ev_o  = scl_f_i & p_q.scl & ~p_q.sda & sda_f_i;

    // R3: a bus condition and a clock edge never coincide
    a_r3_event_vs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ev_o || stop_ev_o) |-> !(scl_rise_o || scl_fall_o));
endmodule

// File: rtl/i2c_rx_engine.sv
module i2c_rx_engine
    import i2c_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              ten_bit_i,
    input  logic              scl_f_i,
    input  logic              sda_f_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_ev_i,
    input  logic              stop_ev_i,
    input  logic              addr_wr_i,
    input  logic [BYTE_W-1:0] addr_wdata_i,
    input  logic              buf_rd_i,
    input  logic              irq_clr_i,
    input  logic              ovf_clr_i,
    output rx_regs_t          regs_o
);
    localparam logic [BITC_W-1:0] LAST_BIT = BITC_W'(BYTE_W - 1);
    localparam logic [BITC_W-1:0] ACK_SLOT = BITC_W'(BYTE_W);
    localparam logic [BITC_W-1:0] ACK_HIGH = BITC_W'(BYTE_W + 1);

    rx_regs_t q, d;

    logic [BYTE_W-1:0] nb;
    logic              hit;
    logic              full_now;
    rx_state_e         hit_st;

    always_comb begin
        nb       = {q.sr[BYTE_W-2:0], sda_f_i};
        full_now = q.full & ~buf_rd_i;
        hit      = 1'b0;
        hit_st   = ST_SKIP;
        unique case (q.st)
            ST_ADDR1: begin
                if (ten_bit_i) begin
                    hit    = (nb[7:3] == 5'b11110) && (nb[7:1] == q.addr[7:1]);
                    hit_st = nb[0] ? ST_SKIP : ST_ADDR2;
                end else begin
                    hit    = (nb[7:1] == q.addr[7:1]);
                    hit_st = nb[0] ? ST_SKIP : ST_DATA;
                end
            end
            ST_ADDR2: begin
                hit    = (nb == q.addr);
                hit_st = ST_DATA;
            end
            ST_DATA: begin
                hit    = 1'b1;
                hit_st = ST_DATA;
            end
            default: begin
                hit    = 1'b0;
                hit_st = ST_SKIP;
            end
        endcase
    end

    always_comb begin
        d = q;
        if (addr_wr_i) begin
            d.addr = addr_wdata_i;
            d.upd  = 1'b0;
        end
        if (buf_rd_i)  d.full = 1'b0;
        if (irq_clr_i) d.irq  = 1'b0;
        if (ovf_clr_i) d.ovf  = 1'b0;

        if (!en_i) begin
            d.st   = ST_IDLE;
            d.cnt  = '0;
            d.ack  = 1'b0;
            d.pull = 1'b0;
        end else if (start_ev_i) begin
            d.st    = ST_ADDR1;
            d.cnt   = '0;
            d.ack   = 1'b0;
            d.pull  = 1'b0;
            d.start = 1'b1;
            d.stop  = 1'b0;
            d.irq   = 1'b1;
        end else if (stop_ev_i) begin
            d.st    = ST_IDLE;
            d.cnt   = '0;
            d.ack   = 1'b0;
            d.pull  = 1'b0;
            d.stop  = 1'b1;
            d.start = 1'b0;
            d.irq   = 1'b1;
        end else if (q.st != ST_IDLE) begin
            if (scl_rise_i) begin
                if (q.cnt < ACK_SLOT) begin
                    d.sr  = nb;
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == LAST_BIT) begin
                        if (hit) begin
                            d.st  = hit_st;
                            d.irq = 1'b1;
                            if (q.st == ST_ADDR1) begin
                                d.is_read = nb[0];
                                d.upd     = ten_bit_i & ~nb[0];
                            end
                            if (full_now) begin
                                d.ovf = 1'b1;
                                d.ack = 1'b0;
                            end else begin
                                d.buf_b   = nb;
                                d.full    = 1'b1;
                                d.is_data = (q.st == ST_DATA);
                                d.ack     = 1'b1;
                            end
                        end else begin
                            d.st  = ST_SKIP;
                            d.ack = 1'b0;
                        end
                    end
                end else if (q.cnt == ACK_SLOT) begin
                    d.cnt = ACK_HIGH;
                end
            end else if (scl_fall_i) begin
                if (q.cnt == ACK_SLOT && q.ack) begin
                    d.pull = 1'b1;
                end else if (q.cnt == ACK_HIGH) begin
                    d.pull = 1'b0;
                    d.ack  = 1'b0;
                    d.cnt  = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, sr: '0, cnt: '0, ack: 1'b0, pull: 1'b0,
                   buf_b: '0, full: 1'b0, ovf: 1'b0, irq: 1'b0, start: 1'b0,
                   stop: 1'b0, is_data: 1'b0, is_read: 1'b0, upd: 1'b0,
                   addr: '0};
        end else begin
            q <= d;
        end
    end

    assign regs_o = q;

    // R3: START and STOP status are never both set
    a_r3_start_stop_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.start && q.stop));
    // R13: the acknowledge pull starts only while SCL is low
    a_r13_pull_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.pull) |-> !scl_f_i);
    // R2: a disabled block never pulls the data line
    a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !q.pull);
    // R8: an overflow leaves the buffer untouched
    a_r8_ovf_keeps_buf: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ovf) |-> $stable(q.buf_b));
    // R4: every buffer load raises the interrupt flag
    a_r4_load_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.full) |-> q.irq);
endmodule

// File: rtl/i2c_rx_target.sv
module i2c_rx_target
    import i2c_rx_pkg::*;
#(
    parameter int FILT_LEN = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       ten_bit_i,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    input  logic       addr_wr_i,
    input  logic [7:0] addr_wdata_i,
    input  logic       buf_rd_i,
    output logic [7:0] buf_o,
    input  logic       irq_clr_i,
    input  logic       ovf_clr_i,
    output logic       irq_o,
    output logic       ovf_o,
    output logic       full_o,
    output logic       start_o,
    output logic       stop_o,
    output logic       is_data_o,
    output logic       is_read_o,
    output logic       upd_addr_o
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines;
    logic [NLINES-1:0] filt_lines;
    logic scl_rise, scl_fall, start_ev, stop_ev;
    rx_regs_t regs;

    assign raw_lines = {sda_i, scl_i};

    for (genvar li = 0; li < NLINES; li++) begin : g_filt
        i2c_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .in_i  (raw_lines[li]),
            .out_o (filt_lines[li])
        );
    end

    i2c_bus_events u_events (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_f_i    (filt_lines[0]),
        .sda_f_i    (filt_lines[1]),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_ev_o (start_ev),
        .stop_ev_o  (stop_ev)
    );

    i2c_rx_engine u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (en_i),
        .ten_bit_i    (ten_bit_i),
        .scl_f_i      (filt_lines[0]),
        .sda_f_i      (filt_lines[1]),
        .scl_rise_i   (scl_rise),
        .scl_fall_i   (scl_fall),
        .start_ev_i   (start_ev),
        .stop_ev_i    (stop_ev),
        .addr_wr_i    (addr_wr_i),
        .addr_wdata_i (addr_wdata_i),
        .buf_rd_i     (buf_rd_i),
        .irq_clr_i    (irq_clr_i),
        .ovf_clr_i    (ovf_clr_i),
        .regs_o       (regs)
    );

    assign sda_pull_o = regs.pull;
    assign buf_o      = regs.buf_b;
    assign irq_o      = regs.irq;
    assign ovf_o      = regs.ovf;
    assign full_o     = regs.full;
    assign start_o    = regs.start;
    assign stop_o     = regs.stop;
    assign is_data_o  = regs.is_data;
    assign is_read_o  = regs.is_read;
    assign upd_addr_o = regs.upd;
endmodule

// File: tb/i2c_rx_target_test.sv
module i2c_rx_target_test;
    localparam int HALF = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_i = 1'b0, ten_bit_i = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic addr_wr_i = 1'b0, buf_rd_i = 1'b0, irq_clr_i = 1'b0, ovf_clr_i = 1'b0;
    logic [7:0] addr_wdata_i = 8'h00;
    logic sda_pull_o, irq_o, ovf_o, full_o, start_o, stop_o;
    logic is_data_o, is_read_o, upd_addr_o;
    logic [7:0] buf_o;
    logic sda_bus;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull_o;

    i2c_rx_target uut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .ten_bit_i(ten_bit_i),
        .scl_i(scl_m), .sda_i(sda_bus), .sda_pull_o(sda_pull_o),
        .addr_wr_i(addr_wr_i), .addr_wdata_i(addr_wdata_i),
        .buf_rd_i(buf_rd_i), .buf_o(buf_o),
        .irq_clr_i(irq_clr_i), .ovf_clr_i(ovf_clr_i),
        .irq_o(irq_o), .ovf_o(ovf_o), .full_o(full_o),
        .start_o(start_o), .stop_o(stop_o), .is_data_o(is_data_o),
        .is_read_o(is_read_o), .upd_addr_o(upd_addr_o)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wclk(HALF);
        scl_m = 1'b1; wclk(HALF);
        sda_m = 1'b0; wclk(HALF);
        scl_m = 1'b0; wclk(HALF);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wclk(HALF);
        scl_m = 1'b1; wclk(HALF);
        sda_m = 1'b1; wclk(HALF);
    endtask

    task automatic bus_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wclk(HALF);
            scl_m = 1'b1; wclk(HALF);
            scl_m = 1'b0;
        end
        sda_m = 1'b1; wclk(HALF);
        scl_m = 1'b1; wclk(HALF / 2);
        acked = ~sda_bus;
        wclk(HALF / 2);
        scl_m = 1'b0; wclk(HALF);
    endtask

    task automatic host_pulse_addr(input logic [7:0] a);
        addr_wdata_i = a; addr_wr_i = 1'b1; wclk(1); addr_wr_i = 1'b0; wclk(1);
    endtask

    task automatic host_read();
        buf_rd_i = 1'b1; wclk(1); buf_rd_i = 1'b0; wclk(1);
    endtask

    task automatic host_clr_irq();
        irq_clr_i = 1'b1; wclk(1); irq_clr_i = 1'b0; wclk(1);
    endtask

    task automatic t_reset();
        chk("R1 irq", irq_o, 0);
        chk("R1 ovf", ovf_o, 0);
        chk("R1 full", full_o, 0);
        chk("R1 start/stop", {start_o, stop_o}, 0);
        chk("R1 flags", {is_data_o, is_read_o, upd_addr_o, sda_pull_o}, 0);
    endtask

    task automatic t_disabled();
        logic a;
        en_i = 1'b0;
        host_pulse_addr(8'hA0);
        bus_start();
        bus_byte(8'hA0, a);
        bus_stop();
        chk("R2 no ack", a, 0);
        chk("R2 no events", {start_o, stop_o, irq_o, full_o}, 0);
        en_i = 1'b1; wclk(2);
    endtask

    task automatic t_glitch();
        sda_m = 1'b0; wclk(2); sda_m = 1'b1; wclk(10);
        chk("R12 glitch no start", {start_o, irq_o}, 0);
    endtask

    task automatic t_7bit_match();
        logic a;
        bus_start();
        chk("R3 start set", {start_o, stop_o, irq_o}, 3'b101);
        host_clr_irq();
        bus_byte(8'hA0, a);
        chk("R4 ack", a, 1);
        chk("R4 buf", buf_o, 8'hA0);
        chk("R4 status", {full_o, irq_o, is_data_o, is_read_o}, 4'b1100);
        chk("R7 irq holds", irq_o, 1);
        host_read();
        chk("R7 read clears full", full_o, 0);
        chk("R7 irq still set", irq_o, 1);
        host_clr_irq();
        chk("R7 irq cleared", irq_o, 0);
        bus_byte(8'h3C, a);
        chk("R6 data ack", a, 1);
        chk("R6 data buf", {buf_o, is_data_o}, {8'h3C, 1'b1});
        chk("R13 released", sda_pull_o, 0);
        host_read();
        bus_stop();
        chk("R3 stop set", {start_o, stop_o, irq_o}, 3'b011);
        host_clr_irq();
    endtask

    task automatic t_overflow();
        logic a;
        bus_start(); host_clr_irq();
        bus_byte(8'hA0, a);
        chk("R8 addr ack", a, 1);
        host_clr_irq();
        bus_byte(8'h55, a);
        chk("R8 nack", a, 0);
        chk("R8 ovf irq", {ovf_o, irq_o}, 2'b11);
        chk("R8 buf kept", buf_o, 8'hA0);
        bus_stop();
        chk("R7 ovf holds", ovf_o, 1);
        ovf_clr_i = 1'b1; wclk(1); ovf_clr_i = 1'b0; wclk(1);
        chk("R7 ovf cleared", ovf_o, 0);
        host_read(); host_clr_irq();
    endtask

    task automatic t_mismatch_and_read();
        logic a;
        bus_start();
        bus_byte(8'h42, a);
        chk("R5 nack", a, 0);
        bus_byte(8'h11, a);
        chk("R5 ignored", {a, full_o}, 0);
        bus_stop(); host_clr_irq();
        bus_start();
        bus_byte(8'hA1, a);
        chk("R4 read ack", a, 1);
        chk("R4 read dir", {is_read_o, is_data_o}, 2'b10);
        bus_stop();
        host_read(); host_clr_irq();
    endtask

    task automatic t_ten_bit();
        logic a;
        ten_bit_i = 1'b1;
        host_pulse_addr(8'hF2);
        bus_start();
        bus_byte(8'hF2, a);
        chk("R9 high ack", a, 1);
        chk("R9 upd set", {upd_addr_o, is_read_o}, 2'b10);
        host_read();
        host_pulse_addr(8'h5A);
        chk("R10 upd cleared", upd_addr_o, 0);
        bus_byte(8'h5A, a);
        chk("R10 low ack", {a, buf_o}, {1'b1, 8'h5A});
        host_read();
        bus_byte(8'h77, a);
        chk("R10 data", {a, buf_o, is_data_o}, {1'b1, 8'h77, 1'b1});
        host_read();
        bus_stop();
        host_pulse_addr(8'hF2);
        bus_start();
        bus_byte(8'hF2, a);
        host_read();
        host_pulse_addr(8'h5A);
        bus_byte(8'h5B, a);
        chk("R11 low nack", {a, full_o}, 0);
        bus_stop();
        ten_bit_i = 1'b0;
        host_clr_irq();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wclk(3);
        rst_n = 1'b1;
        wclk(3);
        t_reset();
        t_disabled();
        t_glitch();
        host_pulse_addr(8'hA0);
        t_7bit_match();
        t_overflow();
        t_mismatch_and_read();
        t_ten_bit();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule